// File: doc/BRIEF.md
# Frame Clock Lock Monitor

This block watches a frame clock that arrives from outside while the converter runs as a timing slave. The frame clock must stay frequency-locked to the local system clock. There is no fixed phase between the two. A counter inside the block advances on a bit-period reference strobe and wraps once per sample period. At each rising frame edge the block reads that counter to measure how far the edge has moved from the position where it was last aligned.

Small drift is tolerated. Large drift is treated as loss of lock. When lock is lost, the output path is forced to the zero code at once. The block then waits for the next rising frame edge, re-anchors its counter to that edge, and keeps the output muted for a fixed number of sample periods before converted data may flow again. A separate window of hysteresis decides when the lock flag is set and when it is cleared. A sticky flag records that a loss has happened.

When the slave enable is low, the monitor is idle. It then reports lock and never mutes.

Top module: `frame_lock_monitor`

## Requirements
- R1: After reset with slaveEn high: inSync=0, muteZero=1, realignStb=0, lossSticky=0.
- R2: In the unaligned state, a rising frame edge produces a one-cycle realignStb pulse in the cycle after the edge is sampled. The bit-period counter restarts from that edge, so the next edge reads the number of bitTick strobes in between, modulo the frame length.
- R3: A drift magnitude above 6 bit periods, seen at an edge while aligned, clears inSync, sets muteZero and lossSticky in the next cycle, and causes a realignment at the following rising edge.
- R4: While running, a drift magnitude below 5 leaves inSync=1 and muteZero=0 and gives no realignStb.
- R5: A drift magnitude of exactly 5 or 6 leaves inSync unchanged. It stays 0 while acquiring and stays 1 while running.
- R6: After a realignment, muteZero stays high through the next 90 rising edges. It drops in the cycle after the 90th such edge, provided that edge is not a loss.
- R7: During the mute interval, an edge with drift magnitude below 5 sets inSync.
- R8: If the 90th mute edge also shows a drift above 6, the loss takes priority: the output stays muted, inSync=0, and the next edge realigns.
- R9: With slaveEn low: inSync=1, muteZero=0, realignStb=0, and lossSticky does not change, whatever the frame clock does.
- R10: lossSticky stays set until reset and is cleared by reset.
- R11: Drift is signed. With counter value p and a frame length of 64 bit periods, the drift magnitude is p when p<32 and 64-p otherwise. An early edge is therefore judged the same way as a late edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveEn | input | 1 | High selects slave timing; low makes the monitor idle |
| frameClk | input | 1 | Frame clock, synchronous to clk |
| bitTick | input | 1 | One-cycle strobe per bit period |
| inSync | output | 1 | Lock status |
| muteZero | output | 1 | Forces the output path to the zero code |
| realignStb | output | 1 | One-cycle pulse when the counter is re-anchored |
| lossSticky | output | 1 | Set on any loss of lock; cleared only by reset |

## Verification
Two events can fall on the same frame edge: mute expiry and loss detection. This happens when the edge that ends the 90-period mute also carries a drift of 7. The bench counts 89 clean mute edges, then lengthens one frame so that the 90th edge arrives 7 bit periods late. It then expects muteZero to stay high, inSync to stay low, and a realignment pulse to appear on the edge after that. The bench also checks the hysteresis band, with drift 5 and 6, both while acquiring and while running.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    ST_ALIGN = 2'd0,
    ST_MUTE  = 2'd1,
    ST_RUN   = 2'd2
  } monState_t;

  // strobes from control to the phase datapath
  typedef struct packed {
    logic realign;
    logic muteClr;
    logic muteInc;
  } monCtl_t;
endpackage

// File: rtl/fsync_phase_dp.sv
module fsync_phase_dp
  import fsync_pkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int LOSE_TICKS  = 6,
  parameter int KEEP_TICKS  = 5,
  parameter int MUTE_FRAMES = 90
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameClk,
  input  logic    bitTick,
  input  monCtl_t ctl,
  output logic    frameRise,
  output logic    driftSmall,
  output logic    driftLarge,
  output logic    muteLast
);
  localparam int PW = $clog2(FRAME_TICKS);
  localparam int MW = $clog2(MUTE_FRAMES + 1);
  localparam logic [PW:0]   HALF_L  = (PW + 1)'(FRAME_TICKS / 2);
  localparam logic [PW:0]   FRAME_L = (PW + 1)'(FRAME_TICKS);
  localparam logic [PW:0]   KEEP_L  = (PW + 1)'(KEEP_TICKS);
  localparam logic [PW:0]   LOSE_L  = (PW + 1)'(LOSE_TICKS);
  localparam logic [MW-1:0] LAST_L  = MW'(MUTE_FRAMES - 1);

  logic          frameQ;
  logic [PW-1:0] phaseCnt;
  logic [PW-1:0] phaseInc;
  logic [PW:0]   phaseExt;
  logic [PW:0]   driftMag;
  logic [MW-1:0] muteCnt;

  always_ff @(posedge clk) begin
    if (!rstN) frameQ <= 1'b0;
    else       frameQ <= frameClk;
  end
  assign frameRise = frameClk & ~frameQ;

  // wrap of the bit-period counter: natural for powers of two
  generate
    if ((FRAME_TICKS & (FRAME_TICKS - 1)) == 0) begin : g_pow2
      assign phaseInc = phaseCnt + 1'b1;
    end else begin : g_mod
      assign phaseInc = (phaseCnt == PW'(FRAME_TICKS - 1)) ? '0 : phaseCnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctl.realign) phaseCnt <= PW'(bitTick);
    else if (bitTick)     phaseCnt <= phaseInc;
  end

  // signed distance of the edge from the aligned position
  assign phaseExt   = {1'b0, phaseCnt};
  assign driftMag   = (phaseExt < HALF_L) ? phaseExt : FRAME_L - phaseExt;
  assign driftSmall = driftMag < KEEP_L;
  assign driftLarge = driftMag > LOSE_L;

  always_ff @(posedge clk) begin
    if (!rstN)                         muteCnt <= '0;
    else if (ctl.muteClr)              muteCnt <= '0;
    else if (ctl.muteInc && !muteLast) muteCnt <= muteCnt + 1'b1;
  end
  assign muteLast = muteCnt == LAST_L;

  // R2
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.realign |=> (phaseCnt <= PW'(1)));

  // R6
  mute_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    muteCnt <= LAST_L);
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
  import fsync_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    slaveEn,
  input  logic    frameRise,
  input  logic    driftSmall,
  input  logic    driftLarge,
  input  logic    muteLast,
  output monCtl_t ctl,
  output logic    inSync,
  output logic    muteZero,
  output logic    realignStb,
  output logic    lossSticky
);
  monState_t state, nextState;
  logic      syncQ;
  logic      lose;

  always_comb begin
    ctl       = '0;
    nextState = state;
    lose      = 1'b0;
    if (!slaveEn) begin
      nextState = ST_ALIGN;
    end else if (frameRise) begin
      case (state)
        ST_ALIGN: begin
          ctl.realign = 1'b1;
          ctl.muteClr = 1'b1;
          nextState   = ST_MUTE;
        end
        ST_MUTE: begin
          if (driftLarge) begin
            lose      = 1'b1;
            nextState = ST_ALIGN;
          end else begin
            ctl.muteInc = 1'b1;
            if (muteLast) nextState = ST_RUN;
          end
        end
        ST_RUN: begin
          if (driftLarge) begin
            lose      = 1'b1;
            nextState = ST_ALIGN;
          end
        end
        default: nextState = ST_ALIGN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_ALIGN;
      syncQ      <= 1'b0;
      lossSticky <= 1'b0;
      realignStb <= 1'b0;
    end else begin
      state      <= nextState;
      realignStb <= ctl.realign;
      if (lose) lossSticky <= 1'b1;
      if (!slaveEn) syncQ <= 1'b0;
      else if (frameRise && state != ST_ALIGN) begin
        if (driftLarge)      syncQ <= 1'b0;
        else if (driftSmall) syncQ <= 1'b1;
      end
    end
  end

  assign inSync   = !slaveEn | syncQ;
  assign muteZero = slaveEn & (state != ST_RUN);

  // R3
  loss_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveEn && frameRise && driftLarge && state != ST_ALIGN)
      |=> (state == ST_ALIGN && !syncQ && lossSticky));

  // R4
  small_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveEn && frameRise && driftSmall && state == ST_RUN)
      |=> (state == ST_RUN && syncQ && !realignStb));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossSticky |=> lossSticky);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveEn && !lossSticky) |=> !lossSticky);

  // R2
  stb_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    realignStb |-> state == ST_MUTE);
endmodule

// File: rtl/frame_lock_monitor.sv
module frame_lock_monitor
  import fsync_pkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int LOSE_TICKS  = 6,
  parameter int KEEP_TICKS  = 5,
  parameter int MUTE_FRAMES = 90
) (
  input  logic clk,
  input  logic rstN,
  input  logic slaveEn,
  input  logic frameClk,
  input  logic bitTick,
  output logic inSync,
  output logic muteZero,
  output logic realignStb,
  output logic lossSticky
);
  monCtl_t ctl;
  logic    frameRise;
  logic    driftSmall;
  logic    driftLarge;
  logic    muteLast;

  fsync_phase_dp #(
    .FRAME_TICKS(FRAME_TICKS),
    .LOSE_TICKS (LOSE_TICKS),
    .KEEP_TICKS (KEEP_TICKS),
    .MUTE_FRAMES(MUTE_FRAMES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frameClk  (frameClk),
    .bitTick   (bitTick),
    .ctl       (ctl),
    .frameRise (frameRise),
    .driftSmall(driftSmall),
    .driftLarge(driftLarge),
    .muteLast  (muteLast)
  );

  fsync_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slaveEn   (slaveEn),
    .frameRise (frameRise),
    .driftSmall(driftSmall),
    .driftLarge(driftLarge),
    .muteLast  (muteLast),
    .ctl       (ctl),
    .inSync    (inSync),
    .muteZero  (muteZero),
    .realignStb(realignStb),
    .lossSticky(lossSticky)
  );
endmodule

// File: tb/test_frame_lock_monitor.sv
module test_frame_lock_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveEn = 1'b1;
  logic frameClk = 1'b0;
  logic bitTick = 1'b0;
  logic inSync, muteZero, realignStb, lossSticky;
  logic cSync, cMute, cStb, cSticky;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  frame_lock_monitor i_frame_lock_monitor (
    .clk(clk), .rstN(rstN), .slaveEn(slaveEn), .frameClk(frameClk),
    .bitTick(bitTick), .inSync(inSync), .muteZero(muteZero),
    .realignStb(realignStb), .lossSticky(lossSticky)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // rising frame edge now, captured just after it, then len bit periods
  task automatic frame(input int len);
    frameClk = 1'b1;
    bitTick  = 1'b0;
    @(negedge clk);
    cSync = inSync; cMute = muteZero; cStb = realignStb; cSticky = lossSticky;
    for (int i = 0; i < len; i++) begin
      bitTick  = 1'b1;
      frameClk = (i < len / 2);
      @(negedge clk);
      bitTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doReset(input logic slv);
    rstN = 1'b0; frameClk = 1'b0; bitTick = 1'b0; slaveEn = slv;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset;
    doReset(1'b1);
    chk("R1 inSync", inSync, 1'b0);
    chk("R1 muteZero", muteZero, 1'b1);
    chk("R1 realignStb", realignStb, 1'b0);
    chk("R1 lossSticky", lossSticky, 1'b0);
  endtask

  task automatic testStartup;
    frame(69);
    chk("R2 realign pulse", cStb, 1'b1);
    chk("R2 pulse one cycle", realignStb, 1'b0);
    frame(59);                       // edge at drift 5 while acquiring
    chk("R5 acquire hold", cSync, 1'b0);
    chk("R6 muted", cMute, 1'b1);
    frame(64);                       // drift 0
    chk("R7 lock set", cSync, 1'b1);
    for (int k = 3; k <= 89; k++) frame(64);
    chk("R6 muted at edge 89", cMute, 1'b1);
    frame(64);
    chk("R6 released at edge 90", cMute, 1'b0);
    chk("R4 sync kept", cSync, 1'b1);
  endtask

  task automatic testSmallDrift;
    frame(67);
    frame(57);                       // drift +3
    chk("R4 +3 sync", cSync, 1'b1);
    chk("R4 +3 mute", cMute, 1'b0);
    frame(68);                       // drift -4
    chk("R4 -4 sync", cSync, 1'b1);
    chk("R4 -4 stb", cStb, 1'b0);
    frame(64);                       // back to 0
    chk("R4 zero mute", cMute, 1'b0);
  endtask

  task automatic testHystLocked;
    frame(70);
    frame(53);                       // drift +6
    chk("R5 +6 sync", cSync, 1'b1);
    chk("R5 +6 mute", cMute, 1'b0);
    frame(69);                       // drift -5
    chk("R5 R11 -5 sync", cSync, 1'b1);
    chk("R5 R11 -5 stb", cStb, 1'b0);
    frame(64);
  endtask

  task automatic testLossCollision;
    frame(57);
    frame(64);                       // drift -7: loss
    chk("R3 R11 sync lost", cSync, 1'b0);
    chk("R3 mute", cMute, 1'b1);
    chk("R3 sticky", cSticky, 1'b1);
    frame(64);
    chk("R3 realign", cStb, 1'b1);
    for (int k = 1; k <= 88; k++) frame(64);
    frame(71);                       // edge 89 clean
    frame(64);                       // edge 90 at drift +7
    chk("R8 mute kept", cMute, 1'b1);
    chk("R8 sync lost", cSync, 1'b0);
    chk("R8 no pulse", cStb, 1'b0);
    frame(64);
    chk("R8 realign", cStb, 1'b1);
  endtask

  task automatic testSticky;
    for (int k = 1; k <= 89; k++) frame(64);
    chk("R6 muted at edge 89", cMute, 1'b1);
    frame(64);
    chk("R6 released", cMute, 1'b0);
    chk("R10 sticky held", cSticky, 1'b1);
    chk("R7 sync", cSync, 1'b1);
    doReset(1'b1);
    chk("R10 reset clears", lossSticky, 1'b0);
  endtask

  task automatic testSlaveOff;
    doReset(1'b0);
    chk("R9 sync", inSync, 1'b1);
    chk("R9 mute", muteZero, 1'b0);
    frame(64); frame(80); frame(40);
    chk("R9 wild sync", cSync, 1'b1);
    chk("R9 wild mute", cMute, 1'b0);
    frame(64);
    chk("R9 no pulse", cStb, 1'b0);
    chk("R9 sticky", cSticky, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testStartup();
    testSmallDrift();
    testHystLocked();
    testLossCollision();
    testSticky();
    testSlaveOff();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule